// File: doc/BRIEF.md
# MDIO Management Master

This block is the management-port master of an Ethernet MAC. Host software programs it through a small word-indexed register port. It then drives the two-wire management bus to a PHY, either to write one 16-bit PHY register or to read one back. It can also poll a single PHY register without end, so that the link state is always current.

The bus clock MDC comes from the system clock through an even divider. The bidirectional data line is split into a driven value, an output enable and a sampled input, and the pad sits outside the block. Software starts a job by setting a command bit. It then polls the busy flag, collects read data from the receive register and writes the command register back to zero.

Top module: `mdio_master`

## Requirements
- R1: During and right after reset, MDC is low, MDIO is not driven, and every register (mode, command, address, transmit data, receive data, status) reads as zero.
- R2: The MDC period in system clocks equals mode bits 7:0 with bit 0 forced to zero. A value below 2 gives a period of 2.
- R3: A write job sends 32 ones as a preamble, or none when mode bit 8 is set. It then sends, MSB first, start 01, opcode 01, the PHY address (address register bits 4:0), the register address (address register bits 12:8), turnaround 10 and the 16 transmit-data bits. MDIO is driven throughout.
- R4: A read job sends the same preamble and header with opcode 10. It releases MDIO for both turnaround bits and all 16 data bits, samples the data on MDC rising edges, and places the result in receive-data bits 15:0.
- R5: Status bit 1 (busy) reads 1 from the clock after a job is accepted until the job completes. MDIO is never driven while busy is 0.
- R6: A job starts only when a command register write turns a command bit from 0 to 1 while busy is 0. Rewriting a bit that is already set, or writing while busy, starts nothing.
- R7: Command bit 0 starts a scan. The block reads PHY register 1 of the addressed PHY again and again for as long as bit 0 stays set. Status bit 0 (link fail) is the inverse of bit 2 of each scanned value. Status bit 2 (invalid) is 1 from the start of the scan until the first scanned read completes. Receive data holds the latest scanned value.
- R8: Register word indices are 0 mode, 1 command, 2 address, 3 transmit data, 4 receive data and 5 status. Reads return the written fields, with all other bits zero, and writes to indices 4 and 5 are ignored.
- R9: When several command bits rise in one write, write (bit 2) wins over read (bit 1), and read wins over scan (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO driver enable |
| mdio_in | input | 1 | Sampled MDIO line |

## Verification
The checker verifies three things on every clock. The data line and its enable change only on MDC falling edges. The line is driven only while busy is set. The link-fail bit and invalid flag move only while a job is in flight. The bench's scenarios cover the rest, using a PHY model that decodes each frame: preamble length, header fields and turnaround for each divider and preamble setting; read data returned through the receive register; MDC periods for every small divider value; and the command rules, which are rising-edge starts, ignored writes while busy, priority, and scan with a link change.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;
  localparam logic [2:0] RIDX_MODE = 3'd0;
  localparam logic [2:0] RIDX_CMD  = 3'd1;
  localparam logic [2:0] RIDX_ADDR = 3'd2;
  localparam logic [2:0] RIDX_TXD  = 3'd3;
  localparam logic [2:0] RIDX_RXD  = 3'd4;
  localparam logic [2:0] RIDX_STAT = 3'd5;

  localparam int unsigned CMD_SCAN  = 0;
  localparam int unsigned CMD_READ  = 1;
  localparam int unsigned CMD_WRITE = 2;

  localparam int unsigned ST_LINKFAIL = 0;
  localparam int unsigned ST_BUSY     = 1;
  localparam int unsigned ST_INVALID  = 2;

  typedef enum logic [1:0] {
    JOB_NONE,
    JOB_WRITE,
    JOB_READ,
    JOB_SCAN
  } job_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int unsigned HALF_W = DIV_W - 1;
  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  logic [HALF_W-1:0] half;
  logic [HALF_W-1:0] cnt_q;
  logic              wrap;

  // bit 0 of the divider is dropped: half period is div/2, at least 1
  always_comb begin
    half = div_i[DIV_W-1:1];
    if (half == '0) half = ONE;
  end

  assign wrap   = (cnt_q >= (half - ONE));
  assign rise_o = wrap & ~mdc_o;
  assign fall_o = wrap &  mdc_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_o <= ~mdc_o;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
  parameter int unsigned PHY_W   = 5,
  parameter int unsigned REG_W   = 5,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic              no_pre_i,
  input  logic [PHY_W-1:0]  phy_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_in_i,
  output logic              mdio_out_o,
  output logic              mdio_oe_o,
  output logic              active_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned HDR_LEN   = 4 + PHY_W + REG_W;
  localparam int unsigned FRAME_LEN = HDR_LEN + 2 + DATA_W;
  localparam int unsigned MAX_LEN   = PRE_LEN + FRAME_LEN;
  localparam int unsigned IDX_W     = $clog2(MAX_LEN + 1);
  localparam logic [IDX_W-1:0] PRE_CNT    = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] HDR_CNT    = IDX_W'(HDR_LEN);
  localparam logic [IDX_W-1:0] FRM_CNT    = IDX_W'(FRAME_LEN);
  localparam logic [IDX_W-1:0] SAMPLE_OFS = IDX_W'(HDR_LEN + 3);
  localparam logic [IDX_W-1:0] IDX_ONE    = IDX_W'(1);

  logic [FRAME_LEN-1:0] frame_q;
  logic [IDX_W-1:0]     idx_q;
  logic [IDX_W-1:0]     pre_q;
  logic [IDX_W-1:0]     end_idx;
  logic                 rd_q;
  logic                 active_q;
  logic                 out_q;
  logic                 oe_q;
  logic                 done_q;
  logic [DATA_W-1:0]    shift_q;
  logic                 in_pre;
  logic                 drive_bit;
  logic                 sample_now;

  assign end_idx    = pre_q + FRM_CNT;
  assign in_pre     = (idx_q < pre_q);
  // bits past the header of a read belong to the PHY
  assign drive_bit  = !rd_q || ((idx_q - pre_q) < HDR_CNT);
  // bit on the line is idx-1; data bits start at frame offset HDR+2
  assign sample_now = active_q && rd_q && (idx_q >= (pre_q + SAMPLE_OFS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q  <= '0;
      idx_q    <= '0;
      pre_q    <= '0;
      rd_q     <= 1'b0;
      active_q <= 1'b0;
      out_q    <= 1'b0;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
      shift_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          idx_q    <= '0;
          pre_q    <= no_pre_i ? '0 : PRE_CNT;
          rd_q     <= rd_i;
          frame_q  <= {2'b01, (rd_i ? 2'b10 : 2'b01), phy_i, reg_i,
                       (rd_i ? 2'b11 : 2'b10), (wdata_i & {DATA_W{~rd_i}})};
        end
      end else if (fall_i) begin
        if (idx_q == end_idx) begin
          active_q <= 1'b0;
          oe_q     <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_ONE;
          if (in_pre) begin
            out_q <= 1'b1;
            oe_q  <= 1'b1;
          end else begin
            out_q   <= frame_q[FRAME_LEN-1];
            frame_q <= {frame_q[FRAME_LEN-2:0], 1'b0};
            oe_q    <= drive_bit;
          end
        end
      end else if (rise_i && sample_now) begin
        shift_q <= {shift_q[DATA_W-2:0], mdio_in_i};
      end
    end
  end

  assign mdio_out_o = out_q;
  assign mdio_oe_o  = oe_q;
  assign active_o   = active_q;
  assign done_o     = done_q;
  assign rdata_o    = shift_q;
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_master_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LINK_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr_i,
  input  logic [2:0]        cmd_old_i,
  input  logic [2:0]        cmd_new_i,
  input  logic              scan_req_i,
  input  logic              eng_active_i,
  input  logic              eng_done_i,
  input  logic [DATA_W-1:0] eng_rdata_i,
  output logic              start_o,
  output logic              start_rd_o,
  output logic              scan_sel_o,
  output logic              busy_o,
  output logic              invalid_o,
  output logic              link_fail_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic [2:0]        fresh;
  logic              start_host;
  logic              busy;
  logic              scan_on_q;
  logic              again_q;
  logic              invalid_q;
  logic              link_fail_q;
  logic [DATA_W-1:0] rx_q;
  job_e              job_q;
  job_e              job_next;

  assign fresh      = cmd_new_i & ~cmd_old_i;
  assign busy       = eng_active_i | scan_on_q | again_q;
  assign start_host = cmd_wr_i && !busy && (fresh != 3'b000);

  always_comb begin
    if (fresh[CMD_WRITE])     job_next = JOB_WRITE;
    else if (fresh[CMD_READ]) job_next = JOB_READ;
    else                      job_next = JOB_SCAN;
  end

  assign start_o    = start_host | again_q;
  assign start_rd_o = again_q | (job_next != JOB_WRITE);
  assign scan_sel_o = again_q | (job_next == JOB_SCAN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_on_q   <= 1'b0;
      again_q     <= 1'b0;
      invalid_q   <= 1'b0;
      link_fail_q <= 1'b0;
      rx_q        <= '0;
      job_q       <= JOB_NONE;
    end else begin
      again_q <= 1'b0;
      if (eng_done_i) begin
        if (job_q != JOB_WRITE) rx_q <= eng_rdata_i;
        if (job_q == JOB_SCAN) begin
          link_fail_q <= ~eng_rdata_i[LINK_BIT];
          invalid_q   <= 1'b0;
          if (scan_req_i) again_q   <= 1'b1;
          else            scan_on_q <= 1'b0;
        end
      end
      if (start_host) begin
        job_q <= job_next;
        if (job_next == JOB_SCAN) begin
          scan_on_q <= 1'b1;
          invalid_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy;
  assign invalid_o   = invalid_q;
  assign link_fail_o = link_fail_q;
  assign rx_data_o   = rx_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_master_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned PHY_W    = 5,
  parameter int unsigned REG_W    = 5,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned PRE_LEN  = 32,
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned SCAN_REG = 1,
  parameter int unsigned LINK_BIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  output logic             mdc,
  output logic             mdio_out,
  output logic             mdio_oe,
  input  logic             mdio_in
);
  localparam int unsigned REGA_LSB = 8;
  localparam int unsigned NOPRE_BIT = DIV_W;
  localparam logic [REG_W-1:0] SCAN_ADDR = REG_W'(SCAN_REG);

  logic [DIV_W:0]    mode_q;
  logic [2:0]        cmd_q;
  logic [PHY_W-1:0]  phy_q;
  logic [REG_W-1:0]  rega_q;
  logic [DATA_W-1:0] tx_q;

  logic              cmd_wr;
  logic              mdc_rise;
  logic              mdc_fall;
  logic              eng_start;
  logic              eng_rd;
  logic              scan_sel;
  logic              eng_active;
  logic              eng_done;
  logic [DATA_W-1:0] eng_rdata;
  logic              st_busy;
  logic              st_invalid;
  logic              st_linkfail;
  logic [DATA_W-1:0] rx_data;

  assign cmd_wr = reg_wr && (reg_addr == RIDX_CMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      cmd_q  <= '0;
      phy_q  <= '0;
      rega_q <= '0;
      tx_q   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RIDX_MODE: mode_q <= reg_wdata[DIV_W:0];
        RIDX_CMD:  cmd_q  <= reg_wdata[2:0];
        RIDX_ADDR: begin
          phy_q  <= reg_wdata[PHY_W-1:0];
          rega_q <= reg_wdata[REGA_LSB +: REG_W];
        end
        RIDX_TXD:  tx_q   <= reg_wdata[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RIDX_MODE: reg_rdata[DIV_W:0] = mode_q;
      RIDX_CMD:  reg_rdata[2:0] = cmd_q;
      RIDX_ADDR: begin
        reg_rdata[PHY_W-1:0]          = phy_q;
        reg_rdata[REGA_LSB +: REG_W]  = rega_q;
      end
      RIDX_TXD:  reg_rdata[DATA_W-1:0] = tx_q;
      RIDX_RXD:  reg_rdata[DATA_W-1:0] = rx_data;
      RIDX_STAT: begin
        reg_rdata[ST_LINKFAIL] = st_linkfail;
        reg_rdata[ST_BUSY]     = st_busy;
        reg_rdata[ST_INVALID]  = st_invalid;
      end
      default: ;
    endcase
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_i  (mode_q[DIV_W-1:0]),
    .mdc_o  (mdc),
    .rise_o (mdc_rise),
    .fall_o (mdc_fall)
  );

  mdio_cmd_ctrl #(.DATA_W(DATA_W), .LINK_BIT(LINK_BIT)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr_i     (cmd_wr),
    .cmd_old_i    (cmd_q),
    .cmd_new_i    (reg_wdata[2:0]),
    .scan_req_i   (cmd_q[CMD_SCAN]),
    .eng_active_i (eng_active),
    .eng_done_i   (eng_done),
    .eng_rdata_i  (eng_rdata),
    .start_o      (eng_start),
    .start_rd_o   (eng_rd),
    .scan_sel_o   (scan_sel),
    .busy_o       (st_busy),
    .invalid_o    (st_invalid),
    .link_fail_o  (st_linkfail),
    .rx_data_o    (rx_data)
  );

  mdio_frame_engine #(
    .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (eng_start),
    .rd_i       (eng_rd),
    .no_pre_i   (mode_q[NOPRE_BIT]),
    .phy_i      (phy_q),
    .reg_i      (scan_sel ? SCAN_ADDR : rega_q),
    .wdata_i    (tx_q),
    .rise_i     (mdc_rise),
    .fall_i     (mdc_fall),
    .mdio_in_i  (mdio_in),
    .mdio_out_o (mdio_out),
    .mdio_oe_o  (mdio_oe),
    .active_o   (eng_active),
    .done_o     (eng_done),
    .rdata_o    (eng_rdata)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst_n,
  input logic mdc,
  input logic mdio_out,
  input logic mdio_oe,
  input logic busy,
  input logic invalid,
  input logic link_fail
);
  p_oe_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  p_out_moves_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_out) |-> !mdc);

  p_oe_moves_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> !mdc);

  p_invalid_in_scan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> busy);

  p_link_held_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(link_fail));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mdc       (mdc),
  .mdio_out  (mdio_out),
  .mdio_oe   (mdio_oe),
  .busy      (st_busy),
  .invalid   (st_invalid),
  .link_fail (st_linkfail)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int CLK_HALF = 10;
  localparam int CLK_PER  = 2 * CLK_HALF;
  localparam logic [2:0] I_MODE = 3'd0, I_CMD = 3'd1, I_ADDR = 3'd2,
                         I_TXD = 3'd3, I_RXD = 3'd4, I_STAT = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in;

  int n_chk = 0;
  int n_bad = 0;

  // PHY model state
  int          ones_run = 0;
  int          m_pre = 0;
  int          rd_count = 0;
  int          wr_count = 0;
  logic [12:0] hdr;
  logic [17:0] wbits;
  logic [4:0]  m_phy, m_reg;
  logic [1:0]  m_op;
  logic        m_st_ok;
  logic        m_oe_ok;
  logic [15:0] m_wdata;
  logic [1:0]  m_ta;
  logic        link_up = 1'b1;

  always #CLK_HALF clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  function automatic logic [15:0] phy_resp(input logic [4:0] p, input logic [4:0] r,
                                           input logic lk);
    logic [15:0] v;
    v = {p, r, 6'b100110};
    if (r == 5'd1) v[2] = lk;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    bit done;
    done = 0;
    for (int i = 0; i < 20000 && !done; i++) begin
      host_rd(I_STAT, s);
      if (!s[1]) done = 1;
    end
    chk(req, {31'd0, done}, 32'd1);
  endtask

  // PHY model: decodes frames on MDC rising edges, answers reads after falling edges
  initial begin : phy_model
    mdio_in = 1'b1;
    forever begin
      @(posedge mdc);
      if (mdio_oe && mdio_out) ones_run++;
      else if (mdio_oe && !mdio_out) begin
        m_pre = ones_run;
        ones_run = 0;
        for (int i = 0; i < 13; i++) begin
          @(posedge mdc);
          hdr = {hdr[11:0], mdio_out};
        end
        m_st_ok = hdr[12];
        m_op  = hdr[11:10];
        m_phy = hdr[9:5];
        m_reg = hdr[4:0];
        if (m_op == 2'b10) begin
          m_oe_ok = 1'b1;
          @(negedge mdc); mdio_in = 1'b1;
          @(posedge mdc); if (mdio_oe) m_oe_ok = 1'b0;
          @(negedge mdc); mdio_in = 1'b0;
          @(posedge mdc); if (mdio_oe) m_oe_ok = 1'b0;
          for (int i = 0; i < 16; i++) begin
            @(negedge mdc); mdio_in = phy_resp(m_phy, m_reg, link_up)[15-i];
            @(posedge mdc); if (mdio_oe) m_oe_ok = 1'b0;
          end
          @(negedge mdc); mdio_in = 1'b1;
          rd_count++;
        end else begin
          m_oe_ok = 1'b1;
          for (int i = 0; i < 18; i++) begin
            @(posedge mdc);
            wbits = {wbits[16:0], mdio_out};
            if (!mdio_oe) m_oe_ok = 1'b0;
          end
          m_ta = wbits[17:16];
          m_wdata = wbits[15:0];
          wr_count++;
        end
      end else ones_run = 0;
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int wc, rc;
    realtime t0, t1;
    logic [4:0] p, r;
    logic [15:0] wd;
    logic [7:0] dv;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 mdc in reset", {31'd0, mdc}, 32'd0);
    chk("R1 oe in reset", {31'd0, mdio_oe}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 oe after reset", {31'd0, mdio_oe}, 32'd0);
    for (int a = 0; a < 6; a++) begin
      host_rd(3'(a), d);
      chk("R1 register zero", d, 32'd0);
    end

    // R8: field readback and read-only registers
    host_wr(I_MODE, 32'hFFFF_FFFF); host_rd(I_MODE, d); chk("R8 mode", d, 32'h1FF);
    host_wr(I_ADDR, 32'hFFFF_FFFF); host_rd(I_ADDR, d); chk("R8 address", d, 32'h1F1F);
    host_wr(I_TXD, 32'hFFFF_ABCD);  host_rd(I_TXD, d);  chk("R8 txdata", d, 32'hABCD);
    host_wr(I_RXD, 32'hFFFF_FFFF);  host_rd(I_RXD, d);  chk("R8 rxdata ro", d, 32'd0);
    host_wr(I_STAT, 32'hFFFF_FFFF); host_rd(I_STAT, d); chk("R8 status ro", d, 32'd0);

    // R2: MDC period over small divider values
    for (int k = 0; k < 10; k++) begin
      host_wr(I_MODE, 32'(k));
      @(posedge mdc); @(posedge mdc);
      t0 = $realtime;
      @(posedge mdc);
      t1 = $realtime;
      chk("R2 mdc period", 32'(int'((t1 - t0) / CLK_PER)), (k < 2) ? 32'd2 : 32'(k & ~1));
    end

    // R3 R4 R5: sweep of writes and reads
    for (int di = 0; di < 3; di++) begin
      for (int np = 0; np < 2; np++) begin
        for (int k = 0; k < 4; k++) begin
          dv = 8'(2 * di + 2 + ((k == 3) ? 1 : 0));
          p  = 5'(k * 11 + di * 5 + 3);
          r  = 5'(k * 7 + np * 3 + 2);
          wd = 16'(k * 16'h1357) ^ 16'(di * 16'h0F0F) ^ 16'(np * 16'h8001);
          host_wr(I_MODE, {23'd0, np[0], dv});
          host_wr(I_ADDR, {19'd0, r, 3'd0, p});
          host_wr(I_TXD, {16'd0, wd});
          host_wr(I_CMD, 32'd0);
          wc = wr_count;
          host_wr(I_CMD, 32'd4);
          host_rd(I_STAT, d);
          chk("R5 busy after write cmd", {31'd0, d[1]}, 32'd1);
          wait_idle("R5 write completes");
          chk("R5 released when idle", {31'd0, mdio_oe}, 32'd0);
          chk("R3 one write frame", 32'(wr_count), 32'(wc + 1));
          chk("R3 preamble", 32'(m_pre), np ? 32'd0 : 32'd32);
          chk("R3 start and op", {29'd0, m_st_ok, m_op}, {29'd0, 1'b1, 2'b01});
          chk("R3 phy and reg", {22'd0, m_phy, m_reg}, {22'd0, p, r});
          chk("R3 turnaround", {30'd0, m_ta}, 32'd2);
          chk("R3 data", {16'd0, m_wdata}, {16'd0, wd});
          chk("R3 driven", {31'd0, m_oe_ok}, 32'd1);

          host_wr(I_CMD, 32'd0);
          rc = rd_count;
          host_wr(I_CMD, 32'd2);
          wait_idle("R5 read completes");
          chk("R4 one read frame", 32'(rd_count), 32'(rc + 1));
          chk("R4 preamble", 32'(m_pre), np ? 32'd0 : 32'd32);
          chk("R4 op and addr", {20'd0, m_op, m_phy, m_reg}, {20'd0, 2'b10, p, r});
          chk("R4 released", {31'd0, m_oe_ok}, 32'd1);
          host_rd(I_RXD, d);
          chk("R4 read data", d, {16'd0, phy_resp(p, r, link_up)});
        end
      end
    end

    // R6: rewriting a set bit starts nothing
    rc = rd_count; wc = wr_count;
    host_wr(I_CMD, 32'd2);
    repeat (600) @(negedge clk);
    chk("R6 no restart on held bit", 32'(rd_count), 32'(rc));
    host_rd(I_STAT, d);
    chk("R6 stays idle", {31'd0, d[1]}, 32'd0);

    // R6: command while busy is ignored
    host_wr(I_CMD, 32'd0);
    host_wr(I_CMD, 32'd4);
    host_wr(I_CMD, 32'd6);
    wait_idle("R6 write completes");
    repeat (600) @(negedge clk);
    chk("R6 write done", 32'(wr_count), 32'(wc + 1));
    chk("R6 read ignored while busy", 32'(rd_count), 32'(rc));

    // R9: priority
    host_wr(I_CMD, 32'd0);
    wc = wr_count; rc = rd_count;
    host_wr(I_CMD, 32'd7);
    wait_idle("R9 job completes");
    chk("R9 write wins", 32'(wr_count), 32'(wc + 1));
    chk("R9 no read", 32'(rd_count), 32'(rc));
    host_rd(I_STAT, d);
    chk("R9 no scan", d, 32'd0);
    host_wr(I_CMD, 32'd0);
    wc = wr_count;
    host_wr(I_CMD, 32'd3);
    wait_idle("R9 read completes");
    chk("R9 read over scan", {27'd0, m_op, 1'b0, 2'(wr_count - wc)}, {27'd0, 2'b10, 1'b0, 2'd0});

    // R7: scan
    host_wr(I_CMD, 32'd0);
    host_wr(I_MODE, 32'd2);
    host_wr(I_ADDR, {19'd0, 5'd9, 3'd0, 5'd7});
    link_up = 1'b1;
    rc = rd_count;
    host_wr(I_CMD, 32'd1);
    host_rd(I_STAT, d);
    chk("R7 busy and invalid at start", d[2:0], 3'b110);
    begin : wait_valid
      for (int i = 0; i < 5000; i++) begin
        host_rd(I_STAT, d);
        if (!d[2]) disable wait_valid;
      end
    end
    chk("R7 valid, link ok", d, 32'd2);
    chk("R7 scans register 1", {27'd0, m_reg}, {27'd0, 5'd1});
    chk("R7 scans phy", {27'd0, m_phy}, {27'd0, 5'd7});
    host_rd(I_RXD, d);
    chk("R7 scan data", d, {16'd0, phy_resp(5'd7, 5'd1, 1'b1)});
    link_up = 1'b0;
    begin : wait_fail
      for (int i = 0; i < 5000; i++) begin
        host_rd(I_STAT, d);
        if (d[0]) disable wait_fail;
      end
    end
    chk("R7 link fail seen", {31'd0, d[0]}, 32'd1);
    chk("R7 repeated reads", {31'd0, 1'(rd_count >= rc + 2)}, 32'd1);
    host_wr(I_CMD, 32'd0);
    wait_idle("R7 scan stops");
    rc = rd_count;
    repeat (600) @(negedge clk);
    chk("R7 no reads after stop", 32'(rd_count), 32'(rc));
    host_rd(I_STAT, d);
    chk("R7 final status", d, 32'd1);
    host_rd(I_RXD, d);
    chk("R7 last scan data", d, {16'd0, phy_resp(5'd7, 5'd1, 1'b0)});

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule